// File: doc/BRIEF.md
# Mirrored-Window Address Decoder

The decoder sits between a bus fabric and the devices of a small secure microcontroller subsystem. It is given a 32-bit request address with a valid strobe. One cycle later it reports which device owns that address as a one-hot select. It also reports the de-aliased address, the offset within the device, and a miss flag that sends the access to a default slave. It does not handle bus protocol or security checks, and it does not contain the devices.

Three 256 MB windows mirror the window directly below them. An address in a mirror window whose bit 28 is set resolves as the same address with bit 28 cleared. The mirror has the lowest priority. A small set of control devices is mapped directly into the 0x5xxx_xxxx window, and these devices win over the mirrored target. Several SRAM banks and the register block of one protection controller per bank are set by a parameter.

Top module: `mirror_addr_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rsp_valid`, `rsp_miss`, `rsp_sel`, `rsp_addr` and `rsp_off` are all zero.
- R2: `rsp_valid` equals `req_valid` delayed by one clock.
- R3: Each fixed device is selected when address bits [31:12] equal its 4 KB page. Bit 0 is timer A at 0x40000, bit 1 is timer B at 0x40001, bit 2 is the dual timer at 0x40002, bit 3 is system info at 0x40020, bit 4 is the slow timer at 0x4002F, bit 5 is the security controller at 0x40080 and 0x50080, and bit 6 is the non-secure watchdog at 0x40081.
- R4: For each bank i below NBANK, SRAM bank i is the 32 KB range at 0x2000_0000 + i*0x8000 and drives select bit 10+i. Addresses beyond the last bank miss.
- R5: The protection-controller register page for bank i is 0x50083 + i. It drives select bit 10+NBANK+i.
- R6: An address in window 1, 3 or 5 (bits [31:28]) that has no direct owner decodes as the address with bit 28 cleared. `rsp_addr` then carries that cleared address.
- R7: Pages that exist only in window 5 take priority over the mirror. These are system control at 0x50021 (bit 7), the slow watchdog at 0x5002E (bit 8), the secure watchdog at 0x50081 (bit 9) and the R5 pages. For a direct hit, `rsp_addr` is the request address unchanged.
- R8: An address with no owner, direct or mirrored, sets `rsp_miss` and gives zero select and zero offset. `rsp_addr` is the de-aliased address.
- R9: The offset is address[14:0] for an SRAM bank and zero-extended address[11:0] for any other device.
- R10: A cycle with `req_valid` low leaves `rsp_sel`, `rsp_addr`, `rsp_off` and `rsp_miss` unchanged.
- R11: At most one select bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Registered copy of req_valid |
| rsp_sel | output | 10+2*NBANK | One-hot target select |
| rsp_addr | output | 32 | De-aliased address |
| rsp_off | output | 15 | Offset within the selected device |
| rsp_miss | output | 1 | No owner: route to default slave |

## Verification
The hardest case to reach is an address where the direct map and the mirror disagree. Examples are 0x5008_1000, where the mirror would give the non-secure watchdog, and the banked register pages, whose mirrored image lands on unmapped space. The bench reaches these cases by sweeping every 4 KB page of the low 576 KB of all eight windows, with NBANK set to 3. This sweep covers every device page, the first SRAM page that does not exist, and every mirror collision. A varying low-address pattern exercises the offsets. A model of the address map built in the bench decides the expected owner of each address.

// File: rtl/mad_pkg.sv
package mad_pkg;
  localparam int FIXED_TGTS = 10;
  localparam int SEC_IDX    = 5;
  localparam logic [19:0] SEC_PAGE_HI = 20'h50080;
  localparam logic [16:0] RAM_BLK0    = 17'h04000;
  localparam logic [19:0] PROT_PAGE0  = 20'h50083;

  function automatic logic [19:0] fixed_page(input int idx);
    case (idx)
      0:       return 20'h40000;
      1:       return 20'h40001;
      2:       return 20'h40002;
      3:       return 20'h40020;
      4:       return 20'h4002F;
      5:       return 20'h40080;
      6:       return 20'h40081;
      7:       return 20'h50021;
      8:       return 20'h5002E;
      default: return 20'h50081;
    endcase
  endfunction
endpackage

// File: rtl/addr_window_dec.sv
module addr_window_dec
  import mad_pkg::*;
#(
  parameter int NBANK = 2,
  localparam int NT = FIXED_TGTS + 2 * NBANK
) (
  input  logic [31:0]   addr,
  output logic [NT-1:0] hit,
  output logic          ram_hit
);
  for (genvar g = 0; g < FIXED_TGTS; g++) begin : g_fixed
    if (g == SEC_IDX) begin : g_two_view
      assign hit[g] = (addr[31:12] == fixed_page(g)) || (addr[31:12] == SEC_PAGE_HI);
    end else begin : g_one_view
      assign hit[g] = (addr[31:12] == fixed_page(g));
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign hit[FIXED_TGTS + b]         = (addr[31:15] == RAM_BLK0 + 17'(b));
    assign hit[FIXED_TGTS + NBANK + b] = (addr[31:12] == PROT_PAGE0 + 20'(b));
  end

  assign ram_hit = |hit[FIXED_TGTS +: NBANK];
endmodule

// File: rtl/alias_merge.sv
module alias_merge #(
  parameter int NT = 14
) (
  input  logic [31:0]   addr,
  input  logic [31:0]   fold_addr,
  input  logic [NT-1:0] raw_hit,
  input  logic          raw_ram,
  input  logic [NT-1:0] fold_hit,
  input  logic          fold_ram,
  output logic [NT-1:0] sel,
  output logic [31:0]   canon,
  output logic [14:0]   off,
  output logic          miss
);
  logic mirror_win;
  logic use_ram;

  assign mirror_win = addr[28] && (addr[31:29] <= 3'd2);

  always_comb begin
    sel     = '0;
    canon   = addr;
    use_ram = 1'b0;
    miss    = 1'b0;
    if (|raw_hit) begin
      sel     = raw_hit;
      use_ram = raw_ram;
    end else if (mirror_win && (|fold_hit)) begin
      sel     = fold_hit;
      canon   = fold_addr;
      use_ram = fold_ram;
    end else begin
      miss = 1'b1;
      if (mirror_win) canon = fold_addr;
    end
    if (miss)         off = '0;
    else if (use_ram) off = addr[14:0];
    else              off = {3'b000, addr[11:0]};
  end
endmodule

// File: rtl/dec_out_reg.sv
module dec_out_reg #(
  parameter int NT = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NT-1:0] sel_d,
  input  logic [31:0]   canon_d,
  input  logic [14:0]   off_d,
  input  logic          miss_d,
  output logic          vld_q,
  output logic [NT-1:0] sel_q,
  output logic [31:0]   canon_q,
  output logic [14:0]   off_q,
  output logic          miss_q
);
  logic [NT-1:0] sel_n;
  logic [31:0]   canon_n;
  logic [14:0]   off_n;
  logic          miss_n;

  always_comb begin
    sel_n   = sel_q;
    canon_n = canon_q;
    off_n   = off_q;
    miss_n  = miss_q;
    if (en) begin
      sel_n   = sel_d;
      canon_n = canon_d;
      off_n   = off_d;
      miss_n  = miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      sel_q   <= '0;
      canon_q <= '0;
      off_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      vld_q   <= en;
      sel_q   <= sel_n;
      canon_q <= canon_n;
      off_q   <= off_n;
      miss_q  <= miss_n;
    end
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_q));
  // R8
  miss_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |-> (sel_q == '0 && off_q == '0));
  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> vld_q);
  // R2
  vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !vld_q);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sel_q) && $stable(canon_q) && $stable(off_q) && $stable(miss_q)));
endmodule

// File: rtl/mirror_addr_decoder.sv
module mirror_addr_decoder
  import mad_pkg::*;
#(
  parameter int NBANK = 2,
  localparam int NT = FIXED_TGTS + 2 * NBANK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  output logic          rsp_valid,
  output logic [NT-1:0] rsp_sel,
  output logic [31:0]   rsp_addr,
  output logic [14:0]   rsp_off,
  output logic          rsp_miss
);
  logic [1:0]    rst_pipe;
  logic          s_rst_n;
  logic [31:0]   fold_addr;
  logic [NT-1:0] raw_hit, fold_hit, sel_d;
  logic          raw_ram, fold_ram, miss_d;
  logic [31:0]   canon_d;
  logic [14:0]   off_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign s_rst_n = rst_pipe[1];

  assign fold_addr = {req_addr[31:29], 1'b0, req_addr[27:0]};

  addr_window_dec #(.NBANK(NBANK)) u_raw (
    .addr(req_addr), .hit(raw_hit), .ram_hit(raw_ram));

  addr_window_dec #(.NBANK(NBANK)) u_fold (
    .addr(fold_addr), .hit(fold_hit), .ram_hit(fold_ram));

  alias_merge #(.NT(NT)) u_merge (
    .addr(req_addr), .fold_addr(fold_addr),
    .raw_hit(raw_hit), .raw_ram(raw_ram),
    .fold_hit(fold_hit), .fold_ram(fold_ram),
    .sel(sel_d), .canon(canon_d), .off(off_d), .miss(miss_d));

  dec_out_reg #(.NT(NT)) u_oreg (
    .clk(clk), .rst_n(s_rst_n), .en(req_valid),
    .sel_d(sel_d), .canon_d(canon_d), .off_d(off_d), .miss_d(miss_d),
    .vld_q(rsp_valid), .sel_q(rsp_sel), .canon_q(rsp_addr),
    .off_q(rsp_off), .miss_q(rsp_miss));
endmodule

// File: tb/sim_mirror_addr_decoder.sv
module sim_mirror_addr_decoder;
  localparam int NB = 3;
  localparam int NT = 10 + 2 * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [31:0]   req_addr;
  logic          rsp_valid;
  logic [NT-1:0] rsp_sel;
  logic [31:0]   rsp_addr;
  logic [14:0]   rsp_off;
  logic          rsp_miss;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mirror_addr_decoder #(.NBANK(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_sel(rsp_sel), .rsp_addr(rsp_addr),
    .rsp_off(rsp_off), .rsp_miss(rsp_miss));

  // Address-map model: owner index of an address without mirroring, or -1.
  function automatic int owner(input logic [31:0] a);
    logic [19:0] pg;
    pg = a[31:12];
    case (pg)
      20'h40000: return 0;
      20'h40001: return 1;
      20'h40002: return 2;
      20'h40020: return 3;
      20'h4002F: return 4;
      20'h40080, 20'h50080: return 5;
      20'h40081: return 6;
      20'h50021: return 7;
      20'h5002E: return 8;
      20'h50081: return 9;
      default: ;
    endcase
    if (a >= 32'h2000_0000 && a < 32'h2000_0000 + NB * 32'h8000)
      return 10 + int'((a - 32'h2000_0000) / 32'h8000);
    if (pg >= 20'h50083 && pg < 20'h50083 + NB)
      return 10 + NB + int'(pg - 20'h50083);
    return -1;
  endfunction

  task automatic check_addr(input logic [31:0] a);
    int idx;
    logic [31:0] e_addr;
    logic [NT-1:0] e_sel;
    logic [14:0] e_off;
    logic e_miss;
    bit mirror;
    string tag;
    mirror = (a[31:28] == 4'h1) || (a[31:28] == 4'h3) || (a[31:28] == 4'h5);
    idx = owner(a);
    e_addr = a;
    tag = "R3";
    if (idx >= 0) begin
      if (mirror) tag = "R7";
      else if (idx >= 10 && idx < 10 + NB) tag = "R4";
      else if (idx >= 10 + NB) tag = "R5";
    end else if (mirror) begin
      e_addr = a & ~32'h1000_0000;
      idx = owner(e_addr);
      tag = (idx >= 0) ? "R6" : "R8";
    end else tag = "R8";
    e_sel = '0;
    e_miss = (idx < 0);
    if (idx >= 0) e_sel[idx] = 1'b1;
    if (idx < 0) e_off = '0;
    else if (idx >= 10 && idx < 10 + NB) e_off = a[14:0];
    else e_off = {3'b000, a[11:0]};
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    @(negedge clk);
    n_chk++;
    if (rsp_sel !== e_sel || rsp_addr !== e_addr || rsp_off !== e_off ||
        rsp_miss !== e_miss || rsp_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL %s (R9 offset, R2 valid) addr=%h sel=%h/%h canon=%h/%h off=%h/%h miss=%b/%b vld=%b/1",
               tag, a, rsp_sel, e_sel, rsp_addr, e_addr, rsp_off, e_off, rsp_miss, e_miss, rsp_valid);
    end
    // R11
    n_chk++;
    if ($countones(rsp_sel) > 1) begin
      n_bad++;
      $display("FAIL R11 addr=%h sel=%h expected at most one bit", a, rsp_sel);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    // R1
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_sel !== '0 || rsp_addr !== '0 || rsp_off !== '0 || rsp_miss !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 vld=%b sel=%h addr=%h off=%h miss=%b expected all 0",
               rsp_valid, rsp_sel, rsp_addr, rsp_off, rsp_miss);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 explicit: peripheral offset drops bits above 11
    check_addr(32'h4000_2ABC);
    // R4 boundary: last byte of last bank, first byte past it
    check_addr(32'h2000_0000 + NB * 32'h8000 - 1);
    check_addr(32'h2000_0000 + NB * 32'h8000);

    for (int r = 0; r < 8; r++) begin
      for (int p = 0; p < 32'h90; p++) begin
        check_addr((32'(r) << 28) | (32'(p) << 12) | ((32'(p) * 37 + 32'(r) * 91) & 32'hFFF));
      end
      for (int p = 0; p < 16; p++) begin
        check_addr((32'(r) << 28) | 32'h0100_0000 | (32'(p) << 12));
      end
    end

    // R10: valid low holds the registered result
    check_addr(32'h5008_1004);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = 32'h4000_0010;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_sel !== (NT'(1) << 9) || rsp_addr !== 32'h5008_1004 ||
        rsp_off !== 15'h004 || rsp_miss !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 vld=%b sel=%h addr=%h off=%h miss=%b expected 0 %h 50081004 004 0",
               rsp_valid, rsp_sel, rsp_addr, rsp_off, rsp_miss, NT'(1) << 9);
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired before the sweep completed");
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule